// File: doc/BRIEF.md
# Contiguous Interrupt Vector Allocator

The allocator owns a table of 128 interrupt lines. Each line has one type: free, link-routed, message-signalled or internal. It serves requests for message-signalled vectors in two forms. One form asks for a block of consecutive vectors and gets the lowest block that fits. The other asks for a single vector and gets the lowest free line. It also serves requests to return a vector and requests to mark a line as taken by a link-routed source. While the input saying that a message-signalled controller is present is low, every request is refused.

A requester places one request on the request port and waits for `req_ready`. Granted vectors are streamed out in ascending order, one per cycle. A single-cycle done pulse then closes the request, with an error flag beside it. The search inspects one table entry per clock. The table is touched by one operation at a time, so a new request waits in front of `req_ready` until the current one has been answered.

Operation codes on `req_op`: 0 = contiguous block, 1 = single vector, 2 = release, 3 = mark link-routed. Line type codes: 0 = free, 1 = link-routed, 2 = message-signalled, 3 = internal.

The sequencer has seven states:

| State | Action | Transitions |
|---|---|---|
| IDLE | Waits for a request. | To FAIL if the controller is absent. To FAIL if the block count is 0. Otherwise to SCAN_RUN, SCAN_ONE or WRITE, by operation. |
| SCAN_RUN | Walks the candidate block. | To GRANT when the block is found. To FAIL when the window is exhausted. |
| SCAN_ONE | Walks single entries. | To GRANT when a free entry is found. To FAIL at the window end. |
| GRANT | Marks and streams one vector per cycle. | To DONE after the last vector. |
| WRITE | Applies a release or a mark. | To DONE. |
| DONE | Success response. | To IDLE. |
| FAIL | Error response. | To IDLE. |

Top module: `vecalloc_top`

## Requirements
- R1: After reset, entries 0 to 7 are internal (code 3) and all others are free (code 0). `req_ready` is 1, and `rsp_done` and `grant_valid` are 0. No grant ever names a vector below 8 or at or above 124. Releasing an internal line does not make it grantable.
- R2: A request accepted while `ctrl_present` is 0 is answered on the next cycle with `rsp_done`=1 and `rsp_err`=1. It gives no grants and leaves the table unchanged.
- R3: Operation 0 grants the lowest-starting block of `req_count` consecutive free entries, starting at 8 or above. The vectors appear in ascending order, one per cycle, on `grant_valid`/`grant_vec`. Each is marked message-signalled. The cycle after the last grant carries `rsp_done`=1 with `rsp_err`=0.
- R4: A block start s is tried only while s + count < 124. If the count is 0, or no block fits, the response is an error with no grants and no table change.
- R5: The block search inspects one entry per cycle. A non-free entry at offset j of candidate s moves the next candidate to s+j+1. The first grant is visible in the cycle after the N-th clock edge following acceptance, where N is the number of entries inspected.
- R6: Operation 1 grants the lowest free entry in 8..123, inspecting one entry per cycle. If none is free, the response is an error.
- R7: Operation 2 sets the entry numbered `req_vec` to free when `req_vec` < 128. A value of 128 or more has no effect. The done pulse without error comes two cycles after acceptance.
- R8: Operation 3 sets the entry numbered `req_vec` to link-routed, so allocations skip it. A value of 128 or more has no effect. The timing is the same as R7.
- R9: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 1 only in the idle state and stays 0 during search, grant and response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_present | input | 1 | Message-signalled controller present |
| req_valid | input | 1 | Request valid |
| req_op | input | 2 | Operation code |
| req_count | input | 7 | Block length for operation 0 |
| req_vec | input | 8 | Vector for operations 2 and 3 |
| req_ready | output | 1 | Idle, able to accept a request |
| rsp_done | output | 1 | Request finished (one-cycle pulse) |
| rsp_err | output | 1 | Request refused, valid with rsp_done |
| grant_valid | output | 1 | A granted vector is present |
| grant_vec | output | 7 | Granted vector number |

## Verification
The hardest situation to reach is a fragmented table in which a block search must skip several blockers before it fits, or runs into the window limit. Reaching it needs a history of mixed grants, releases and link markings. The stimulus builds that history with a long seeded random mix of all four operations, with occasional large counts and absent-controller cycles. A reference table in the bench predicts every grant and every inspection count. Directed sequences cover a fully occupied window, the exact window boundary and release keys of 128 or more.

// File: rtl/vecalloc_pkg.sv
package vecalloc_pkg;

    typedef enum logic [1:0] {
        LT_NONE     = 2'd0,
        LT_LINK     = 2'd1,
        LT_MSG      = 2'd2,
        LT_INTERNAL = 2'd3
    } line_type_e;

    typedef enum logic [1:0] {
        OP_RUN  = 2'd0,
        OP_ONE  = 2'd1,
        OP_FREE = 2'd2,
        OP_LINK = 2'd3
    } alloc_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN_RUN,
        ST_SCAN_ONE,
        ST_GRANT,
        ST_WRITE,
        ST_DONE,
        ST_FAIL
    } seq_state_e;

endpackage

// File: rtl/vecalloc_table.sv
module vecalloc_table
    import vecalloc_pkg::*;
#(
    parameter int ENTRIES  = 128,
    parameter int RESERVED = 8,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output line_type_e       rd_type,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  line_type_e       wr_type
);

    line_type_e lines [ENTRIES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                lines[i] <= (i < RESERVED) ? LT_INTERNAL : LT_NONE;
            end
        end else if (wr_en) begin
            lines[wr_idx] <= wr_type;
        end
    end

    assign rd_type = lines[rd_idx];

endmodule

// File: rtl/vecalloc_seq.sv
module vecalloc_seq
    import vecalloc_pkg::*;
#(
    parameter int ENTRIES    = 128,
    parameter int RESERVED   = 8,
    parameter int WINDOW_END = 124,
    parameter int KEY_W      = 8,
    localparam int IDX_W     = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_present,
    input  logic             req_valid,
    input  alloc_op_e        req_op,
    input  logic [IDX_W-1:0] req_count,
    input  logic [KEY_W-1:0] req_vec,
    output logic             req_ready,
    output logic             rsp_done,
    output logic             rsp_err,
    output logic             grant_valid,
    output logic [IDX_W-1:0] grant_vec,
    output logic [IDX_W-1:0] tbl_rd_idx,
    input  line_type_e       tbl_rd_type,
    output logic             tbl_wr_en,
    output logic [IDX_W-1:0] tbl_wr_idx,
    output line_type_e       tbl_wr_type
);

    localparam logic [IDX_W-1:0] FIRST_I = IDX_W'(RESERVED);
    localparam logic [IDX_W-1:0] LAST_I  = IDX_W'(WINDOW_END);
    localparam logic [IDX_W:0]   END_W   = (IDX_W+1)'(WINDOW_END);
    localparam logic [IDX_W-1:0] ONE_I   = IDX_W'(1);
    localparam logic [KEY_W-1:0] KEY_LIM = KEY_W'(ENTRIES);

    seq_state_e       state_q, state_d;
    alloc_op_e        op_q, op_d;
    logic [IDX_W-1:0] cnt_q, cnt_d;
    logic [KEY_W-1:0] key_q, key_d;
    logic [IDX_W-1:0] base_q, base_d;
    logic [IDX_W-1:0] off_q, off_d;
    logic [IDX_W-1:0] left_q, left_d;

    logic [IDX_W-1:0] probe_idx;
    logic             run_fits;
    logic             key_in_range;

    assign probe_idx    = base_q + off_q;
    assign run_fits     = ({1'b0, base_q} + {1'b0, cnt_q}) < END_W;
    assign key_in_range = key_q < KEY_LIM;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_RUN;
            cnt_q   <= '0;
            key_q   <= '0;
            base_q  <= FIRST_I;
            off_q   <= '0;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            op_q    <= op_d;
            cnt_q   <= cnt_d;
            key_q   <= key_d;
            base_q  <= base_d;
            off_q   <= off_d;
            left_q  <= left_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        op_d    = op_q;
        cnt_d   = cnt_q;
        key_d   = key_q;
        base_d  = base_q;
        off_d   = off_q;
        left_d  = left_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    op_d   = req_op;
                    cnt_d  = req_count;
                    key_d  = req_vec;
                    base_d = FIRST_I;
                    off_d  = '0;
                    if (!ctrl_present) begin
                        state_d = ST_FAIL;
                    end else begin
                        unique case (req_op)
                            OP_RUN:  state_d = (req_count == '0) ? ST_FAIL : ST_SCAN_RUN;
                            OP_ONE:  state_d = ST_SCAN_ONE;
                            default: state_d = ST_WRITE;
                        endcase
                    end
                end
            end
            ST_SCAN_RUN: begin
                if (off_q == '0 && !run_fits) begin
                    state_d = ST_FAIL;
                end else if (tbl_rd_type == LT_NONE) begin
                    if (off_q == cnt_q - ONE_I) begin
                        state_d = ST_GRANT;
                        left_d  = cnt_q;
                    end else begin
                        off_d = off_q + ONE_I;
                    end
                end else begin
                    base_d = probe_idx + ONE_I;
                    off_d  = '0;
                end
            end
            ST_SCAN_ONE: begin
                if (base_q >= LAST_I) begin
                    state_d = ST_FAIL;
                end else if (tbl_rd_type == LT_NONE) begin
                    state_d = ST_GRANT;
                    left_d  = ONE_I;
                end else begin
                    base_d = base_q + ONE_I;
                end
            end
            ST_GRANT: begin
                base_d = base_q + ONE_I;
                left_d = left_q - ONE_I;
                if (left_q == ONE_I) state_d = ST_DONE;
            end
            ST_WRITE: state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            ST_FAIL:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready   = (state_q == ST_IDLE);
        rsp_done    = (state_q == ST_DONE) || (state_q == ST_FAIL);
        rsp_err     = (state_q == ST_FAIL);
        grant_valid = (state_q == ST_GRANT);
        grant_vec   = base_q;
        tbl_rd_idx  = (state_q == ST_SCAN_RUN) ? probe_idx : base_q;
        tbl_wr_en   = 1'b0;
        tbl_wr_idx  = base_q;
        tbl_wr_type = LT_MSG;
        unique case (state_q)
            ST_GRANT: tbl_wr_en = 1'b1;
            ST_WRITE: begin
                tbl_wr_en   = key_in_range;
                tbl_wr_idx  = key_q[IDX_W-1:0];
                tbl_wr_type = (op_q == OP_FREE) ? LT_NONE : LT_LINK;
            end
            default: tbl_wr_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/vecalloc_top.sv
module vecalloc_top
    import vecalloc_pkg::*;
#(
    parameter int ENTRIES    = 128,
    parameter int RESERVED   = 8,
    parameter int WINDOW_END = 124,
    parameter int KEY_W      = 8,
    localparam int IDX_W     = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_present,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic [IDX_W-1:0] req_count,
    input  logic [KEY_W-1:0] req_vec,
    output logic             req_ready,
    output logic             rsp_done,
    output logic             rsp_err,
    output logic             grant_valid,
    output logic [IDX_W-1:0] grant_vec
);

    logic [IDX_W-1:0] rd_idx;
    line_type_e       rd_type;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    line_type_e       wr_type;

    vecalloc_table #(
        .ENTRIES  (ENTRIES),
        .RESERVED (RESERVED)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (rd_idx),
        .rd_type (rd_type),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_type (wr_type)
    );

    vecalloc_seq #(
        .ENTRIES    (ENTRIES),
        .RESERVED   (RESERVED),
        .WINDOW_END (WINDOW_END),
        .KEY_W      (KEY_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_present (ctrl_present),
        .req_valid    (req_valid),
        .req_op       (alloc_op_e'(req_op)),
        .req_count    (req_count),
        .req_vec      (req_vec),
        .req_ready    (req_ready),
        .rsp_done     (rsp_done),
        .rsp_err      (rsp_err),
        .grant_valid  (grant_valid),
        .grant_vec    (grant_vec),
        .tbl_rd_idx   (rd_idx),
        .tbl_rd_type  (rd_type),
        .tbl_wr_en    (wr_en),
        .tbl_wr_idx   (wr_idx),
        .tbl_wr_type  (wr_type)
    );

endmodule

// File: rtl/vecalloc_chk.sv
module vecalloc_chk #(
    parameter int ENTRIES    = 128,
    parameter int RESERVED   = 8,
    parameter int WINDOW_END = 124,
    parameter int KEY_W      = 8,
    localparam int IW        = $clog2(ENTRIES)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ctrl_present,
    input logic          req_valid,
    input logic [1:0]    req_op,
    input logic [IW-1:0] req_count,
    input logic [KEY_W-1:0] req_vec,
    input logic          req_ready,
    input logic          rsp_done,
    input logic          rsp_err,
    input logic          grant_valid,
    input logic [IW-1:0] grant_vec
);

    localparam logic [IW-1:0] LO_V  = IW'(RESERVED);
    localparam logic [IW-1:0] HI_V  = IW'(WINDOW_END);
    localparam logic [IW-1:0] STEP  = IW'(1);

    logic taken;
    assign taken = req_valid && req_ready;

    // R1
    grant_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (grant_vec >= LO_V && grant_vec < HI_V));

    // R2
    absent_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && !ctrl_present) |=> (rsp_done && rsp_err));

    // R3
    grant_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && $past(grant_valid)) |-> (grant_vec == $past(grant_vec) + STEP));

    // R3
    grant_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |=> (grant_valid || (rsp_done && !rsp_err)));

    // R4
    zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && ctrl_present && req_op == 2'd0 && req_count == '0) |=> (rsp_done && rsp_err));

    // R7
    write_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && ctrl_present && req_op[1]) |=> ##1 (rsp_done && !rsp_err));

    // R9
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done || grant_valid) |-> !req_ready);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // req_vec is part of the observed port set
    logic unused_vec;
    assign unused_vec = ^req_vec;

endmodule

bind vecalloc_top vecalloc_chk #(
    .ENTRIES    (ENTRIES),
    .RESERVED   (RESERVED),
    .WINDOW_END (WINDOW_END),
    .KEY_W      (KEY_W)
) u_chk (.*);

// File: tb/test_vecalloc_top.sv
module test_vecalloc_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_present = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_op = 2'd0;
    logic [6:0] req_count = 7'd0;
    logic [7:0] req_vec = 8'd0;
    logic       req_ready, rsp_done, rsp_err, grant_valid;
    logic [6:0] grant_vec;

    int checks = 0;
    int fails  = 0;
    int m_tbl [128];

    always #5 clk = ~clk;

    vecalloc_top i_vecalloc_top (
        .clk(clk), .rst_n(rst_n), .ctrl_present(ctrl_present),
        .req_valid(req_valid), .req_op(req_op), .req_count(req_count),
        .req_vec(req_vec), .req_ready(req_ready), .rsp_done(rsp_done),
        .rsp_err(rsp_err), .grant_valid(grant_valid), .grant_vec(grant_vec)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin : watchdog
        repeat (180000) @(posedge clk);
        check(1'b0, "WDOG", "run did not end", 0, 1);
        finish_run();
    end

    function automatic void model_reset();
        for (int i = 0; i < 128; i++) m_tbl[i] = (i < 8) ? 3 : 0;
    endfunction

    function automatic int model_run(input int cnt, output int n);
        int s = 8;
        int j = 0;
        n = 0;
        if (cnt == 0) return -1;
        forever begin
            if (j == 0 && !(s + cnt < 124)) return -1;
            n++;
            if (m_tbl[s + j] == 0) begin
                if (j == cnt - 1) return s;
                j++;
            end else begin
                s = s + j + 1;
                j = 0;
            end
        end
    endfunction

    function automatic int model_one(output int n);
        n = 0;
        for (int s = 8; s < 124; s++) begin
            n++;
            if (m_tbl[s] == 0) return s;
        end
        return -1;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
    endtask

    task automatic issue(input int op, input int cnt, input int vec,
                         output bit err, output int ng, output int g [128],
                         output int lat_g, output int lat_d, output bit busy_ok);
        int cyc = 0;
        ng = 0; lat_g = -1; lat_d = -1; err = 1'b0; busy_ok = 1'b1;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_op    = 2'(op);
        req_count = 7'(cnt);
        req_vec   = 8'(vec);
        @(posedge clk);
        #1 req_valid = 1'b0;
        forever begin
            @(negedge clk);
            cyc++;
            if (req_ready) busy_ok = 1'b0;
            if (grant_valid) begin
                if (lat_g < 0) lat_g = cyc;
                if (ng < 128) g[ng] = int'(grant_vec);
                ng++;
            end
            if (rsp_done) begin
                lat_d = cyc;
                err = rsp_err;
                break;
            end
            if (cyc > 2000) break;
        end
    endtask

    // Runs one request, predicts with the model, checks, updates the model.
    task automatic apply(input int op, input int cnt, input int vec, input string req);
        bit err, busy_ok;
        int ng, lat_g, lat_d, n, exp_s, exp_n;
        int g [128];
        bit pres = ctrl_present;
        exp_s = -1; exp_n = 0; n = 0;
        if (pres && op == 0) begin exp_s = model_run(cnt, n); exp_n = (exp_s < 0) ? 0 : cnt; end
        if (pres && op == 1) begin exp_s = model_one(n); exp_n = (exp_s < 0) ? 0 : 1; end
        issue(op, cnt, vec, err, ng, g, lat_g, lat_d, busy_ok);
        check(busy_ok, "R9", "ready stayed low while busy", 0, 0);
        if (!pres) begin
            check(err == 1'b1 && ng == 0, "R2", "absent refusal err", int'(err), 1);
            check(lat_d == 1, "R2", "absent refusal latency", lat_d, 1);
            return;
        end
        if (op >= 2) begin
            check(err == 1'b0 && ng == 0, op == 2 ? "R7" : "R8", "write response err", int'(err), 0);
            check(lat_d == 2, op == 2 ? "R7" : "R8", "write response latency", lat_d, 2);
            if (vec < 128) m_tbl[vec] = (op == 2) ? 0 : 1;
            return;
        end
        check(err == (exp_s < 0), op == 0 ? "R4" : "R6", "error flag", int'(err), int'(exp_s < 0));
        check(ng == exp_n, op == 0 ? "R3" : "R6", "grant count", ng, exp_n);
        if (ng == exp_n && exp_s >= 0) begin
            for (int i = 0; i < ng; i++) begin
                check(g[i] == exp_s + i, op == 0 ? "R3" : "R6", "granted vector", g[i], exp_s + i);
                check(g[i] >= 8 && g[i] < 124, "R1", "grant inside window", g[i], exp_s + i);
                m_tbl[exp_s + i] = 2;
            end
            check(lat_g == n + 1, "R5", "first grant latency", lat_g, n + 1);
            check(lat_d == n + 1 + ng, "R3", "done after last grant", lat_d, n + 1 + ng);
        end
    endtask

    initial begin : stimulus
        void'($urandom(32'd2024));
        do_reset();

        // R1 reset state
        check(req_ready == 1'b1, "R1", "req_ready after reset", int'(req_ready), 1);
        check(rsp_done == 1'b0, "R1", "rsp_done after reset", int'(rsp_done), 0);
        check(grant_valid == 1'b0, "R1", "grant_valid after reset", int'(grant_valid), 0);

        // R2 absent controller, then no table change
        ctrl_present = 1'b0;
        apply(0, 2, 0, "R2");
        apply(1, 0, 0, "R2");
        ctrl_present = 1'b1;
        apply(0, 2, 0, "R3");      // expects 8,9
        // R8 blocker, R5 skip past it
        apply(3, 0, 12, "R8");
        apply(0, 4, 0, "R5");      // expects 13..16 after skipping 12
        apply(3, 0, 200, "R8");    // out of range key: no effect
        apply(1, 0, 0, "R6");      // expects 10
        // R4 zero count and window boundary
        apply(0, 0, 0, "R4");
        do_reset();
        apply(0, 116, 0, "R4");    // 8+116 = 124: refused
        apply(0, 115, 0, "R4");    // 8..122
        apply(1, 0, 0, "R6");      // 123
        apply(1, 0, 0, "R6");      // none free: error
        apply(2, 0, 200, "R7");    // no effect
        apply(1, 0, 0, "R7");      // still error
        apply(2, 0, 64, "R7");
        apply(1, 0, 0, "R7");      // 64
        apply(2, 0, 3, "R1");      // internal line released
        apply(1, 0, 0, "R1");      // still error: 3 is outside the window
        apply(0, 1, 0, "R1");

        // random mix
        do_reset();
        for (int k = 0; k < 400; k++) begin
            int r = $urandom_range(0, 19);
            ctrl_present = ($urandom_range(0, 19) != 0);
            if (r < 7)       apply(0, $urandom_range(1, 6), 0, "R3");
            else if (r == 7) apply(0, $urandom_range(0, 127), 0, "R4");
            else if (r < 11) apply(1, 0, 0, "R6");
            else if (r < 17) apply(2, 0, ($urandom_range(0, 3) == 0) ? $urandom_range(0, 255)
                                                                     : $urandom_range(8, 123), "R7");
            else             apply(3, 0, ($urandom_range(0, 3) == 0) ? $urandom_range(0, 255)
                                                                     : $urandom_range(8, 123), "R8");
        end
        finish_run();
    end

endmodule